// File: doc/BRIEF.md
# Gated programmable clock post-divider

The block turns a fast source clock into one divided output clock. A single 32-bit control register, written and read in the system clock domain, sets an integer divide factor from 1 to 31. The same register can stop the divider altogether, and it chooses whether the output follows a consumer request or is held on. Two read-only bits report back to software. One shows whether the output is currently running or gated. The other inverts each time a newly written factor has actually reached the output.

A new factor is never applied in the middle of an output period. The fast-domain counter takes it at the end of the current period, and the acknowledge is then carried back to the system clock domain. Gating and ungating are also applied at a period end, when the output is low, so the output never shows a shortened high pulse. A factor of 1 passes the source clock straight through, using an enable that changes only while the source clock is low.

Top module: `cdiv_top`

## Requirements
- R1: After reset the register reads 32'h0000_0004: the factor (bits 4:0) is 4, and acknowledge, gate control, status and power-down are all 0 while the request is low.
- R2: For a factor N from 2 to 31, each output period lasts N source cycles and its high phase lasts floor(N/2) source cycles.
- R3: A factor of 1 makes the output equal to the source clock: the period is one source cycle and the high phase is half of one.
- R4: A write whose bits 4:0 are 0 leaves the factor field unchanged and does not toggle the acknowledge bit (bit 5).
- R5: A write with a nonzero factor inverts the acknowledge bit (bit 5) exactly once, after the new factor has taken effect, and the factor changes only at the end of an output period while the output is low.
- R6: With gate control (bit 8) at 0, the output stops while the request input is low and runs while the request is high.
- R7: With gate control (bit 8) at 1, the output runs whether or not the request is high.
- R8: The status bit (bit 9) reads 1 while the output is running and 0 while it is gated.
- R9: With power-down (bit 12) at 1, the output is held low and status reads 0. After power-down is cleared, the first output period is a complete period.
- R10: Bits 31:13, 11:10 and 7:6 read 0 and ignore writes. Writes to bits 5 and 9 have no effect.
- R11: The output gate state changes only while the output is low, so gating never cuts a high pulse short.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_sys | input | 1 | System clock for the register port |
| clk_fast | input | 1 | Fast source clock to be divided |
| rst_n | input | 1 | Active-low asynchronous reset for both domains |
| wr_en | input | 1 | Register write strobe, one system cycle per write |
| wdata | input | 32 | Register write data |
| rdata | output | 32 | Register read data |
| req | input | 1 | Consumer request for the output clock |
| clk_out | output | 1 | Divided, gated output clock |

## Verification
On every fast cycle the assertions check four things: the active factor is never zero, the factor and the gate state change only while the output is low, a synchronized power-down forces the output and gate state low, and the acknowledge toggles only at a low boundary. On every system cycle they check that a zero-factor write leaves the factor field unchanged. Only the bench scenarios can show the measured period and high time for several factors, including pass-through. They also show the acknowledge handshake seen from software, gating under request, forced enable and power-down as seen on the status bit and the output edges, and a full first period after power-down is released.

// File: rtl/cdiv_pkg.sv
`timescale 1ns/1ps
package cdiv_pkg;
  localparam int DIVW     = 5;
  localparam int DIV_RST  = 4;
  localparam int REGW     = 32;
  // field positions seen by software
  localparam int B_ACK    = 5;
  localparam int B_FORCE  = 8;
  localparam int B_STAT   = 9;
  localparam int B_PWDN   = 12;

  // number of source cycles the output stays high in one period
  function automatic logic [DIVW-1:0] high_cycles(input logic [DIVW-1:0] n);
    return n >> 1;
  endfunction

  // output level at count position c of a period of length n (n > 1)
  function automatic logic in_high(input logic [DIVW-1:0] n, input logic [DIVW-1:0] c);
    return (n > 1) && (c < high_cycles(n));
  endfunction

  function automatic logic legal_div(input logic [DIVW-1:0] n);
    return n != '0;
  endfunction
endpackage

// File: rtl/cdiv_sync.sv
`timescale 1ns/1ps
module cdiv_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st[0] <= '0;
    else        st[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st[i] <= '0;
      else        st[i] <= st[i-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/cdiv_regs.sv
`timescale 1ns/1ps
module cdiv_regs
  import cdiv_pkg::*;
(
  input  logic            clk_sys,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [REGW-1:0] wdata,
  input  logic            ack_s,
  input  logic            run_s,
  output logic [DIVW-1:0] div_reg,
  output logic            force_on,
  output logic            pwdn,
  output logic            upd_tgl,
  output logic [REGW-1:0] rdata
);
  logic div_ok;
  assign div_ok = legal_div(wdata[DIVW-1:0]);

  always_ff @(posedge clk_sys or negedge rst_n) begin
    if (!rst_n) begin
      div_reg  <= DIVW'(DIV_RST);
      force_on <= 1'b0;
      pwdn     <= 1'b0;
      upd_tgl  <= 1'b0;
    end else if (wr_en) begin
      force_on <= wdata[B_FORCE];
      pwdn     <= wdata[B_PWDN];
      if (div_ok) begin
        div_reg <= wdata[DIVW-1:0];
        upd_tgl <= ~upd_tgl;
      end
    end
  end

  always_comb begin
    rdata              = '0;
    rdata[DIVW-1:0]    = div_reg;
    rdata[B_ACK]       = ack_s;
    rdata[B_FORCE]     = force_on;
    rdata[B_STAT]      = run_s;
    rdata[B_PWDN]      = pwdn;
  end
endmodule

// File: rtl/cdiv_core.sv
`timescale 1ns/1ps
module cdiv_core
  import cdiv_pkg::*;
(
  input  logic            clk_fast,
  input  logic            rst_n,
  input  logic [DIVW-1:0] div_reg,
  input  logic            upd_tgl_s,
  input  logic            pwdn_s,
  input  logic            force_s,
  input  logic            req_s,
  output logic [DIVW-1:0] cur_n,
  output logic            div_q,
  output logic            run,
  output logic            en_lo,
  output logic            ack_f
);
  logic [DIVW-1:0] cnt;
  logic [DIVW-1:0] want_n;
  logic [DIVW-1:0] nxt_n;
  logic            tgl_d;
  logic            pend;
  logic            upd_ev;
  logic            want_run;
  logic            at_end;
  logic            load;

  always_comb begin
    upd_ev   = upd_tgl_s ^ tgl_d;
    want_run = !pwdn_s && (force_s || req_s);
    at_end   = !run || (cnt == cur_n - DIVW'(1));
    load     = at_end && pend && !pwdn_s;
    nxt_n    = load ? want_n : cur_n;
  end

  always_ff @(posedge clk_fast or negedge rst_n) begin
    if (!rst_n) begin
      tgl_d  <= 1'b0;
      want_n <= DIVW'(DIV_RST);
      pend   <= 1'b0;
      cur_n  <= DIVW'(DIV_RST);
      cnt    <= '0;
      run    <= 1'b0;
      div_q  <= 1'b0;
      ack_f  <= 1'b0;
    end else begin
      tgl_d <= upd_tgl_s;
      if (upd_ev) begin
        want_n <= div_reg;
        pend   <= 1'b1;
      end else if (load) begin
        pend   <= 1'b0;
      end
      if (pwdn_s) begin
        cnt   <= '0;
        run   <= 1'b0;
        div_q <= 1'b0;
      end else if (at_end) begin
        cur_n <= nxt_n;
        run   <= want_run;
        cnt   <= '0;
        div_q <= want_run && in_high(nxt_n, '0);
        if (load) ack_f <= ~ack_f;
      end else begin
        cnt   <= cnt + DIVW'(1);
        div_q <= in_high(cur_n, cnt + DIVW'(1));
      end
    end
  end

  // pass-through enable, changes only while the source clock is low
  always_ff @(negedge clk_fast or negedge rst_n) begin
    if (!rst_n) en_lo <= 1'b0;
    else        en_lo <= run;
  end
endmodule

// File: rtl/cdiv_top.sv
`timescale 1ns/1ps
module cdiv_top
  import cdiv_pkg::*;
(
  input  logic        clk_sys,
  input  logic        clk_fast,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  input  logic        req,
  output logic        clk_out
);
  logic [DIVW-1:0] div_reg;
  logic [DIVW-1:0] cur_n;
  logic force_on, pwdn, upd_tgl;
  logic upd_tgl_s, force_s, pwdn_s, req_s;
  logic ack_f, run, div_q, en_lo;
  logic ack_s, run_s;

  cdiv_regs u_regs (
    .clk_sys (clk_sys), .rst_n (rst_n), .wr_en (wr_en), .wdata (wdata),
    .ack_s (ack_s), .run_s (run_s), .div_reg (div_reg), .force_on (force_on),
    .pwdn (pwdn), .upd_tgl (upd_tgl), .rdata (rdata)
  );

  cdiv_sync #(.W(4), .STAGES(2)) u_to_fast (
    .clk (clk_fast), .rst_n (rst_n),
    .d ({upd_tgl, force_on, pwdn, req}),
    .q ({upd_tgl_s, force_s, pwdn_s, req_s})
  );

  cdiv_core u_core (
    .clk_fast (clk_fast), .rst_n (rst_n), .div_reg (div_reg),
    .upd_tgl_s (upd_tgl_s), .pwdn_s (pwdn_s), .force_s (force_s), .req_s (req_s),
    .cur_n (cur_n), .div_q (div_q), .run (run), .en_lo (en_lo), .ack_f (ack_f)
  );

  cdiv_sync #(.W(2), .STAGES(2)) u_to_sys (
    .clk (clk_sys), .rst_n (rst_n),
    .d ({ack_f, run}),
    .q ({ack_s, run_s})
  );

  assign clk_out = (cur_n == DIVW'(1)) ? (clk_fast & en_lo) : div_q;
endmodule

// File: rtl/cdiv_chk.sv
`timescale 1ns/1ps
module cdiv_chk
  import cdiv_pkg::*;
(
  input logic            clk_sys,
  input logic            clk_fast,
  input logic            rst_n,
  input logic            wr_en,
  input logic [31:0]     wdata,
  input logic [31:0]     rdata,
  input logic [DIVW-1:0] cur_n,
  input logic            div_q,
  input logic            run,
  input logic            ack_f,
  input logic            pwdn_s
);
  assert_div_nonzero_R4: assert property (@(posedge clk_fast) disable iff (!rst_n)
    cur_n != '0);

  assert_div_change_low_R5: assert property (@(posedge clk_fast) disable iff (!rst_n)
    !$stable(cur_n) |-> !$past(div_q));

  assert_ack_at_boundary_R5: assert property (@(posedge clk_fast) disable iff (!rst_n)
    !$stable(ack_f) |-> !$past(div_q));

  assert_gate_change_low_R11: assert property (@(posedge clk_fast) disable iff (!rst_n)
    (!$stable(run) && !$past(pwdn_s)) |-> !$past(div_q));

  assert_pwdn_stops_R9: assert property (@(posedge clk_fast) disable iff (!rst_n)
    pwdn_s |=> (!div_q && !run));

  assert_zero_write_kept_R4: assert property (@(posedge clk_sys) disable iff (!rst_n)
    (wr_en && wdata[DIVW-1:0] == '0) |=> $stable(rdata[DIVW-1:0]));
endmodule

bind cdiv_top cdiv_chk u_chk (
  .clk_sys (clk_sys), .clk_fast (clk_fast), .rst_n (rst_n), .wr_en (wr_en),
  .wdata (wdata), .rdata (rdata), .cur_n (cur_n), .div_q (div_q), .run (run),
  .ack_f (ack_f), .pwdn_s (pwdn_s)
);

// File: tb/tb_cdiv_top.sv
`timescale 1ns/1ps
module tb_cdiv_top;
  localparam int SYS_PER  = 10;
  localparam int FAST_PER = 4;

  logic clk_sys = 0, clk_fast = 0, rst_n = 0, wr_en = 0, req = 0;
  logic [31:0] wdata = 0;
  logic [31:0] rdata;
  logic clk_out;

  always #(SYS_PER/2)  clk_sys  = ~clk_sys;
  always #(FAST_PER/2) clk_fast = ~clk_fast;

  cdiv_top dut (.clk_sys(clk_sys), .clk_fast(clk_fast), .rst_n(rst_n), .wr_en(wr_en),
                .wdata(wdata), .rdata(rdata), .req(req), .clk_out(clk_out));

  int n_checks = 0, n_fail = 0;
  int edges = 0;
  int pushed = 0, mon_done = 0;

  typedef struct { int n; longint per; longint hi; } shape_t;
  shape_t exp_q[$];

  always @(posedge clk_out) edges++;

  task automatic check(input bit ok, input string rq, input longint act, input longint expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, expv);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  // monitor: measures one output period per queued item
  initial begin
    forever begin
      shape_t it;
      longint t0, t1, t2;
      wait (exp_q.size() > 0);
      it = exp_q[0];
      @(posedge clk_out); t0 = $time;
      @(negedge clk_out); t1 = $time;
      @(posedge clk_out); t2 = $time;
      check((t2 - t0) == it.per, $sformatf("R2/R3 period n=%0d", it.n), t2 - t0, it.per);
      check((t1 - t0) == it.hi, $sformatf("R2/R3 high n=%0d", it.n), t1 - t0, it.hi);
      void'(exp_q.pop_front());
      mon_done++;
    end
  end

  // driver side of the scoreboard: expected shape from the divide rule
  task automatic expect_shape(input int n);
    shape_t it;
    it.n   = n;
    it.per = longint'(n) * FAST_PER;
    if (n == 1) it.hi = FAST_PER / 2;
    else        it.hi = longint'((n - (n % 2)) / 2) * FAST_PER;
    exp_q.push_back(it);
    pushed++;
    wait (mon_done == pushed);
  endtask

  task automatic wr(input logic [31:0] v);
    @(negedge clk_sys); wr_en = 1; wdata = v;
    @(negedge clk_sys); wr_en = 0; wdata = 0;
  endtask

  task automatic idle(input int c);
    repeat (c) @(negedge clk_sys);
  endtask

  // write a new factor and wait for the acknowledge bit to flip
  task automatic set_div(input int n, input logic [31:0] ctl);
    logic a0;
    int k;
    @(negedge clk_sys); a0 = rdata[5];
    wr(ctl | 32'(n));
    k = 0;
    while (rdata[5] == a0 && k < 300) begin @(negedge clk_sys); k++; end
    check(rdata[5] != a0, "R5 ack toggled", rdata[5], ~a0);
    check(rdata[4:0] == 5'(n), "R5 factor field", rdata[4:0], n);
    idle(3);
    check(rdata[5] != a0, "R5 single toggle", rdata[5], ~a0);
  endtask

  task automatic no_edges(input string rq);
    int e0;
    idle(10);
    e0 = edges;
    idle(40);
    check(edges == e0, rq, edges - e0, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk_sys);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic a0;
    idle(3);
    rst_n = 1;
    idle(2);
    check(rdata == 32'h0000_0004, "R1 reset value", rdata, 32'h4);
    no_edges("R6 gated with request low");
    check(rdata[9] == 0, "R8 status gated", rdata[9], 0);

    req = 1;
    idle(40);
    check(rdata[9] == 1, "R8 status running", rdata[9], 1);
    expect_shape(4);

    set_div(7, 32'h0);  expect_shape(7);
    set_div(2, 32'h0);  expect_shape(2);
    set_div(31, 32'h0); expect_shape(31);
    set_div(1, 32'h0);  expect_shape(1);

    // R4: zero factor write is dropped
    @(negedge clk_sys); a0 = rdata[5];
    wr(32'h0);
    idle(40);
    check(rdata[4:0] == 5'd1, "R4 factor kept", rdata[4:0], 1);
    check(rdata[5] == a0, "R4 no ack toggle", rdata[5], a0);
    expect_shape(1);

    set_div(5, 32'h0);
    req = 0;
    idle(20);
    no_edges("R6 gated after request drop");
    check(rdata[9] == 0, "R8 status gated again", rdata[9], 0);

    wr(32'h0000_0105);
    idle(40);
    check(rdata[9] == 1, "R7 forced running status", rdata[9], 1);
    expect_shape(5);

    wr(32'h0000_1105);
    idle(20);
    check(rdata[9] == 0, "R9 status under power-down", rdata[9], 0);
    no_edges("R9 no output under power-down");
    wr(32'h0000_0105);
    expect_shape(5);  // first period after release

    wr(32'hFFFF_EFE3);
    idle(40);
    check((rdata & ~32'h0000_0220) == 32'h0000_0103, "R10 reserved bits zero",
          rdata & ~32'h0000_0220, 32'h103);
    expect_shape(3);

    finish_run();
  end
endmodule